// File: doc/BRIEF.md
# Late-Write Pipelined-Read Memory Front End

This block is a synchronous single-port memory with a register-register late-write protocol and a pipelined read. On every rising clock edge it samples a select, a write enable, four per-lane write enables and an address. A read command returns its word from an output register one edge after the command edge. A write command takes its data one edge after the address and control were sampled. Each 36-bit word is split into four 9-bit lanes. Any set of lanes can be written, and a write with no lane enabled is an abort.

Write data is held in a pending register for one cycle before it reaches the array. A read that catches a pending write to the same address therefore merges the pending lanes into the array word, which keeps reads and writes fully coherent. A deselect is pipelined to the same depth as read data. An asynchronous output enable and a sleep input gate the bus drive. The block has no tristate pins: the bus is modelled as a data output plus a drive-enable output.

Top module: `lwsram_ctrl`

## Requirements
- R1: A read command (select low, write enable high, sleep low) sampled at edge k puts the addressed word on `dq_o` after edge k+1. `dq_oe_o` is high from edge k+1 until edge k+2, as long as `oe_n_i` is low.
- R2: A write command (select low, write enable low, sleep low) sampled at edge k writes the value present on `wdata_i` at edge k+1 to the address sampled at edge k.
- R3: `bwe_n_i` bit i, active low, enables lane i, which is word bits 9i+8 down to 9i. The enables are taken at the command edge, any combination is legal, and lanes that are not enabled keep their old content.
- R4: A write command with all four `bwe_n_i` bits high is an abort and changes no memory content.
- R5: A deselect (select high) or a write command sampled at edge k leaves `dq_oe_o` low from edge k+1 to edge k+2. Data from a read sampled at edge k-1 is still driven between edge k and edge k+1.
- R6: `oe_n_i` gates the drive without a clock. While `oe_n_i` is high, `dq_oe_o` is low. The output word changes only at an edge that follows a read command.
- R7: While `sleep_i` is high, `dq_oe_o` is low and commands sampled at that time are treated as deselects. Memory contents are kept.
- R8: A read sampled at the edge right after a write command to the same address returns the newly written lanes merged with the older contents of the other lanes.
- R9: A synchronous active-low reset puts the pipeline in the idle, deselected state with `dq_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | Sleep: outputs off, commands ignored |
| sel_n_i | input | 1 | Active-low select |
| we_n_i | input | 1 | Active-low write enable |
| bwe_n_i | input | 4 | Active-low lane write enables |
| addr_i | input | AW (10) | Word address |
| wdata_i | input | 36 | Late write data, one edge after the command |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| dq_o | output | 36 | Read data from the output register |
| dq_oe_o | output | 1 | Bus drive enable (low means high impedance) |

## Verification
The embedded assertions check the pipeline timing on every cycle. A read command must yield a valid output register one edge later. A deselect at the pins must leave the bus undriven two edges later. The output word may move only after a read. Every pending write must trace back to a write command. The data itself can only be shown by the bench's scenarios, which compare every cycle against a behavioural model. These include the merged lanes of a forwarded read, the absence of change after an abort, retention across sleep and partial-lane writes at the top address.

// File: rtl/lwsram_pkg.sv
// Shared definitions for the late-write memory front end.
// Assumes lanes of 9 bits; command codes are internal only.
package lwsram_pkg;
    localparam int LANE_W_DEF = 9;
    localparam int LANES_DEF  = 4;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;
endpackage

// File: rtl/lwsram_cmd_decode.sv
// Command register: samples select, write enable, lane enables and address
// on each rising edge. Sleep or a high select turns the command into idle.
// Assumes inputs are synchronous to clk.
module lwsram_cmd_decode
    import lwsram_pkg::*;
#(
    parameter int AW    = 10,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             sel_n_i,
    input  logic             we_n_i,
    input  logic [LANES-1:0] bwe_n_i,
    input  logic [AW-1:0]    addr_i,
    output cmd_e             cmd_o,
    output logic [AW-1:0]    addr_o,
    output logic [LANES-1:0] lane_en_o
);
    cmd_e cmd_d;

    // Decode the pin-level command into an internal code.
    always_comb begin
        if (sleep_i || sel_n_i) cmd_d = CMD_IDLE;
        else if (we_n_i)        cmd_d = CMD_READ;
        else                    cmd_d = CMD_WRITE;
    end

    // Register the command, address and active-high lane enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o     <= CMD_IDLE;
            addr_o    <= '0;
            lane_en_o <= '0;
        end else begin
            cmd_o     <= cmd_d;
            addr_o    <= addr_i;
            lane_en_o <= ~bwe_n_i;
        end
    end
endmodule

// File: rtl/lwsram_wr_stage.sv
// Late-write stage: one edge after a write command it captures the write
// data together with that command's address and lane enables. The result is
// a pending write that the array commits on the next edge. An abort (no
// lane enabled) produces no pending write.
module lwsram_wr_stage
    import lwsram_pkg::*;
#(
    parameter int AW     = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [LANES-1:0] lane_en_i,
    input  logic [DW-1:0]    wdata_i,
    output logic             pend_vld_o,
    output logic [AW-1:0]    pend_addr_o,
    output logic [LANES-1:0] pend_lanes_o,
    output logic [DW-1:0]    pend_data_o
);
    // Capture the late data for the previous write command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld_o   <= 1'b0;
            pend_addr_o  <= '0;
            pend_lanes_o <= '0;
            pend_data_o  <= '0;
        end else begin
            pend_vld_o   <= (cmd_i == CMD_WRITE) && (|lane_en_i);
            pend_addr_o  <= addr_i;
            pend_lanes_o <= lane_en_i;
            pend_data_o  <= wdata_i;
        end
    end

    // A pending write must come from a write command one edge earlier.
    assert_pend_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != CMD_WRITE) |=> !pend_vld_o);

    // An abort command must never leave a pending write.
    assert_abort_no_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_WRITE && lane_en_i == '0) |=> !pend_vld_o);
endmodule

// File: rtl/lwsram_array.sv
// Behavioural storage array with per-lane write enables and an
// asynchronous read port. It has no reset, so contents stay undefined
// until written.
module lwsram_array #(
    parameter int AW     = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [LANES-1:0] wr_lanes_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [DW-1:0]    rd_data_o
);
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        // Commit one lane of a pending write.
        always_ff @(posedge clk) begin
            if (wr_en_i && wr_lanes_i[ln])
                mem_q[wr_addr_i][ln*LANE_W +: LANE_W] <= wr_data_i[ln*LANE_W +: LANE_W];
        end
    end

    // Asynchronous read of the addressed word.
    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/lwsram_rd_stage.sv
// Read output register. On the edge after a read command it loads the
// array word. Lanes of a same-address pending write, which the array is
// committing at that same edge, are forwarded in. The register holds its
// value on every other edge.
module lwsram_rd_stage
    import lwsram_pkg::*;
#(
    parameter int AW     = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd_i,
    input  logic [AW-1:0]    rd_addr_i,
    input  logic [DW-1:0]    arr_data_i,
    input  logic             pend_vld_i,
    input  logic [AW-1:0]    pend_addr_i,
    input  logic [LANES-1:0] pend_lanes_i,
    input  logic [DW-1:0]    pend_data_i,
    output logic [DW-1:0]    dout_o,
    output logic             dvalid_o
);
    logic          hit;
    logic [DW-1:0] merged;

    assign hit = pend_vld_i && (pend_addr_i == rd_addr_i);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_fwd
        // Pick each lane from the pending write or from the array.
        assign merged[ln*LANE_W +: LANE_W] = (hit && pend_lanes_i[ln])
            ? pend_data_i[ln*LANE_W +: LANE_W]
            : arr_data_i[ln*LANE_W +: LANE_W];
    end

    // Load the output register after a read; otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o   <= '0;
            dvalid_o <= 1'b0;
        end else begin
            dvalid_o <= (cmd_i == CMD_READ);
            if (cmd_i == CMD_READ) dout_o <= merged;
        end
    end

    // A registered read must present valid data one edge later.
    assert_read_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_READ) |=> dvalid_o);

    // Output data moves only after a read command.
    assert_hold_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != CMD_READ) |=> $stable(dout_o));
endmodule

// File: rtl/lwsram_ctrl.sv
// Top of the late-write, pipelined-read memory front end. Assumes all
// inputs except oe_n_i are synchronous to clk. The bus is shown as a data
// output plus a drive enable; the enable is gated by oe_n_i and sleep_i
// without a clock.
module lwsram_ctrl
    import lwsram_pkg::*;
#(
    parameter int AW     = 10,
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             sel_n_i,
    input  logic             we_n_i,
    input  logic [LANES-1:0] bwe_n_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             oe_n_i,
    output logic [DW-1:0]    dq_o,
    output logic             dq_oe_o
);
    cmd_e             cmd_q;
    logic [AW-1:0]    addr_q;
    logic [LANES-1:0] lanes_q;
    logic             pend_vld;
    logic [AW-1:0]    pend_addr;
    logic [LANES-1:0] pend_lanes;
    logic [DW-1:0]    pend_data;
    logic [DW-1:0]    arr_data;
    logic             dvalid;

    lwsram_cmd_decode #(.AW(AW), .LANES(LANES)) u_dec (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .sel_n_i(sel_n_i),
        .we_n_i(we_n_i), .bwe_n_i(bwe_n_i), .addr_i(addr_i),
        .cmd_o(cmd_q), .addr_o(addr_q), .lane_en_o(lanes_q)
    );

    lwsram_wr_stage #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_q), .addr_i(addr_q),
        .lane_en_i(lanes_q), .wdata_i(wdata_i),
        .pend_vld_o(pend_vld), .pend_addr_o(pend_addr),
        .pend_lanes_o(pend_lanes), .pend_data_o(pend_data)
    );

    lwsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .wr_en_i(pend_vld), .wr_addr_i(pend_addr),
        .wr_lanes_i(pend_lanes), .wr_data_i(pend_data),
        .rd_addr_i(addr_q), .rd_data_o(arr_data)
    );

    lwsram_rd_stage #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_q), .rd_addr_i(addr_q),
        .arr_data_i(arr_data), .pend_vld_i(pend_vld), .pend_addr_i(pend_addr),
        .pend_lanes_i(pend_lanes), .pend_data_i(pend_data),
        .dout_o(dq_o), .dvalid_o(dvalid)
    );

    // Drive the bus only with valid read data, enabled output and no sleep.
    assign dq_oe_o = dvalid && !oe_n_i && !sleep_i;

    // A deselect at the pins leaves the bus undriven two edges later.
    assert_desel_undriven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_i |=> ##1 !dq_oe_o);

    // A write at the pins leaves the bus undriven two edges later.
    assert_write_undriven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n_i && !we_n_i) |=> ##1 !dq_oe_o);
endmodule

// File: tb/lwsram_ctrl_tb_top.sv
// Self-checking bench: a behavioural model is updated on every rising edge
// and compared with the outputs on every falling edge.
module lwsram_ctrl_tb_top;
    localparam int AW = 10;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_i = 1'b0;
    logic          sel_n_i = 1'b1;
    logic          we_n_i = 1'b1;
    logic [3:0]    bwe_n_i = 4'hF;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic          oe_n_i = 1'b0;
    logic [DW-1:0] dq_o;
    logic          dq_oe_o;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R9";
    logic [DW-1:0] held_data = '0;

    always #4 clk = ~clk; // 125 MHz

    lwsram_ctrl #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .sel_n_i(sel_n_i),
        .we_n_i(we_n_i), .bwe_n_i(bwe_n_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .oe_n_i(oe_n_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    // Reference model state
    logic [DW-1:0] ref_mem [1 << AW];
    int            m_cmd = 0;      // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_addr;
    logic [3:0]    m_lanes;
    bit            m_pv = 0;
    logic [AW-1:0] m_paddr;
    logic [3:0]    m_plan;
    logic [DW-1:0] m_pdata;
    bit            m_valid = 0;
    logic [DW-1:0] m_out = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = 0; m_pv = 0; m_valid = 0; m_out = '0;
        end else begin
            if (m_cmd == 1) begin
                logic [DW-1:0] w;
                w = ref_mem[m_addr];
                if (m_pv && m_paddr == m_addr)
                    for (int l = 0; l < 4; l++)
                        if (m_plan[l]) w[l*9 +: 9] = m_pdata[l*9 +: 9];
                m_out = w;
                m_valid = 1;
            end else begin
                m_valid = 0;
            end
            if (m_pv)
                for (int l = 0; l < 4; l++)
                    if (m_plan[l]) ref_mem[m_paddr][l*9 +: 9] = m_pdata[l*9 +: 9];
            if (m_cmd == 2) begin
                m_pv = (m_lanes != 4'h0);
                m_paddr = m_addr; m_plan = m_lanes; m_pdata = wdata_i;
            end else begin
                m_pv = 0;
            end
            if (sleep_i || sel_n_i) m_cmd = 0;
            else m_cmd = we_n_i ? 1 : 2;
            m_addr = addr_i;
            m_lanes = ~bwe_n_i;
        end
    end

    task automatic check_now();
        bit exp_oe;
        exp_oe = m_valid && !oe_n_i && !sleep_i;
        n_vec++;
        if (dq_oe_o !== exp_oe) begin
            n_bad++;
            $display("FAIL %s: dq_oe_o actual %b expected %b at %0t", cur_req, dq_oe_o, exp_oe, $time);
        end else if (exp_oe && dq_o !== m_out) begin
            n_bad++;
            $display("FAIL %s: dq_o actual %h expected %h at %0t", cur_req, dq_o, m_out, $time);
        end
    endtask

    // One cycle: check, then drive. Write data given here appears a cycle later.
    task automatic step(input logic s_n, input logic w_n, input logic [3:0] b_n,
                        input logic [AW-1:0] a, input logic [DW-1:0] nd,
                        input logic o_n, input logic slp);
        @(negedge clk);
        check_now();
        sel_n_i = s_n; we_n_i = w_n; bwe_n_i = b_n; addr_i = a;
        wdata_i = held_data; held_data = nd;
        oe_n_i = o_n; sleep_i = slp;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [3:0] b_n, input logic [DW-1:0] d);
        step(1'b0, 1'b0, b_n, a, d, 1'b0, 1'b0);
    endtask
    task automatic rd(input logic [AW-1:0] a);
        step(1'b0, 1'b1, 4'hF, a, '0, 1'b0, 1'b0);
    endtask
    task automatic nop();
        step(1'b1, 1'b1, 4'hF, '0, '0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R9: outputs undriven during and after reset
        cur_req = "R9";
        repeat (3) begin
            @(negedge clk);
            n_vec++;
            if (dq_oe_o !== 1'b0) begin
                n_bad++;
                $display("FAIL R9: dq_oe_o actual %b expected 0", dq_oe_o);
            end
        end
        rst_n = 1'b1;
        nop(); nop();

        // R2: full writes to a working set and the top address
        cur_req = "R2";
        for (int i = 0; i < 16; i++) wr(AW'(i), 4'h0, {4'(i), 32'hA5C3_0000 + 32'(i * 7919)});
        wr({AW{1'b1}}, 4'h0, 36'hF_0F0F_0F0F);
        nop(); nop();

        // R1: back-to-back reads
        cur_req = "R1";
        for (int i = 0; i < 16; i++) rd(AW'(i));
        rd({AW{1'b1}});
        nop(); nop();

        // R3: partial lane writes, then read back
        cur_req = "R3";
        wr(10'd3, 4'b1010, 36'h1_2345_6789);
        wr({AW{1'b1}}, 4'b0111, 36'hE_DCBA_9876);
        nop(); rd(10'd3); rd({AW{1'b1}}); nop(); nop();

        // R4: abort writes leave contents unchanged
        cur_req = "R4";
        wr(10'd5, 4'hF, 36'hB_AD0B_AD0B);
        rd(10'd5); nop(); nop();

        // R8: read right after a partial write to the same address
        cur_req = "R8";
        wr(10'd7, 4'b1100, 36'h3_3333_3333);
        rd(10'd7);
        wr(10'd8, 4'b0001, 36'h0_0000_01FF);
        nop(); rd(10'd8);
        wr(10'd9, 4'h0, 36'h9_9999_9999);
        rd(10'd9); rd(10'd9); nop(); nop();

        // R5: deselect and write after read; earlier read data still shown
        cur_req = "R5";
        rd(10'd1); nop(); rd(10'd2); wr(10'd10, 4'h0, 36'h0_AAAA_5555); rd(10'd10); nop(); nop();

        // R6: output enable gating without a clock
        cur_req = "R6";
        rd(10'd4);
        step(1'b1, 1'b1, 4'hF, '0, '0, 1'b1, 1'b0);
        #1 n_vec++;
        if (dq_oe_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R6: dq_oe_o actual %b expected 0 with oe_n high", dq_oe_o);
        end
        nop(); nop();

        // R7: sleep ignores commands and keeps contents
        cur_req = "R7";
        rd(10'd6);
        step(1'b0, 1'b0, 4'h0, 10'd6, 36'hD_EADD_EADD, 1'b0, 1'b1);
        step(1'b0, 1'b1, 4'hF, 10'd6, '0, 1'b0, 1'b1);
        step(1'b1, 1'b1, 4'hF, '0, '0, 1'b0, 1'b0);
        rd(10'd6); nop(); nop();

        // Mixed traffic across all requirements
        cur_req = "R8 mixed";
        for (int i = 0; i < 400; i++) begin
            int unsigned k;
            logic [AW-1:0] a;
            k = $urandom_range(0, 9);
            a = ($urandom_range(0, 16) == 16) ? {AW{1'b1}} : AW'($urandom_range(0, 15));
            if (k < 4) rd(a);
            else if (k < 7) wr(a, 4'($urandom), {$urandom, 4'($urandom)});
            else if (k < 8) step(1'b1, 1'b1, 4'hF, a, '0, 1'($urandom), 1'b0);
            else if (k < 9) step(1'b0, 1'b1, 4'hF, a, '0, 1'($urandom_range(0, 3) == 0), 1'b0);
            else step(1'($urandom), 1'($urandom), 4'($urandom), a, '0, 1'b0, 1'($urandom_range(0, 3) == 0));
        end
        nop(); nop(); nop();
        finish_run();
    end
endmodule